// File: doc/BRIEF.md
# Serial Peripheral Interface Master Controller

This block is a serial-peripheral-interface master sitting behind a small 32-bit register port. Software programs a clock divider, the clock idle level and sampling edge, a frame length of 1 to 8 bits and a bit order. It then writes frames into a transmit FIFO. A shift engine takes frames from that FIFO one at a time and clocks them out on `mosi`. At the same time it samples `miso`, and every frame it sends leaves exactly one frame in a receive FIFO. To read from a peripheral without writing to it, software sends zero-valued dummy frames.

Chip selects are active low and one-hot. The register that picks the line holds an index into the block's own chip-select outputs. Three chip-select modes are available. In AUTO the line frames each transfer. In HOLD the line is kept low across consecutive frames. In OFF the block leaves every line high so that external logic can drive selection. The FIFO state is reported in bit 31 of the data registers themselves, so a single read returns both the flag and the data.

The engine is a five-state machine. ST_IDLE goes to ST_SETUP when the transmit FIFO holds a frame and the receive FIFO has room. ST_SETUP goes to ST_ACTIVE after one half period; this transition is the leading edge. ST_ACTIVE goes to ST_IDLEHALF after one half period; this transition is the trailing edge. When that trailing edge ends the frame's last bit, ST_ACTIVE goes to ST_HOLDOFF instead. ST_IDLEHALF goes back to ST_ACTIVE after one half period, which is the next leading edge. ST_HOLDOFF goes to ST_IDLE after one half period and stores the received frame.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, `sck` is low and every `cs_n` line is high. Reading word 5 (transmit data) returns bit 31 = 0, meaning not full. Reading word 6 (receive data) returns bit 31 = 1, meaning empty.
- R2: Each SCK half period, from leading edge to trailing edge, lasts DIV+1 clock cycles. DIV is held in bits DIV_W-1:0 of word 0, so the SCK rate is the clock rate divided by 2×(DIV+1).
- R3: Word 1 bit 0 selects the SCK level while no frame is in progress: 0 for low, 1 for high.
- R4: Word 1 bit 1 selects the sampling edge. When it is 0, each bit is presented before the leading edge, and both sides sample on the leading edge. When it is 1, each bit is presented at the leading edge and sampled on the trailing edge. In both settings the peripheral receives the written frame.
- R5: Word 4 holds the frame length in bits 3:0 and the bit order in bit 6, where 1 means LSB-first and 0 means MSB-first. Bits 5:4 form a protocol field that is stored only. A length of 0, or any value above 8, is treated as 8. Received frames are returned right-aligned in bits 7:0 of word 6, with the unused upper bits at zero.
- R6: A write to word 5 stores bits 7:0 as a frame when the transmit FIFO is not full. While the FIFO is full, bit 31 of word 5 reads 1 and further writes are dropped.
- R7: A read of word 6 with bit 31 clear returns the oldest received frame and removes it from the FIFO. A read with bit 31 set changes nothing.
- R8: Each transmitted frame yields exactly one received frame, and no frame starts while the receive FIFO is full.
- R9: In AUTO mode (word 3 bits 1:0 = 0), the selected line goes low for each frame and returns high after it. No more than one line is ever low.
- R10: In HOLD mode (encoding 2), the selected line stays low between consecutive frames. In OFF mode (encoding 3), all lines stay high while frames are being shifted.
- R11: Word 2 gives the index of the `cs_n` bit that is driven. No other bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe; pops the receive FIFO at word 6 |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | NCS | Active-low chip selects |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and NCS = 4, and keeps the other parameters at their defaults. The shallow FIFOs make both limits cheap to reach. Six quick writes fill the transmit FIFO and push one write into the drop path. Five frames then fill the receive FIFO and hold the fifth frame back until the next read. Four chip-select lines let the bench move the selected index away from zero, so that a wrong line being driven shows up. A peripheral model that follows the programmed edge and bit order checks every received bit.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_IDLEHALF,
        ST_HOLDOFF
    } eng_state_t;

    localparam int A_DIV    = 0;
    localparam int A_MODE   = 1;
    localparam int A_CSSEL  = 2;
    localparam int A_CSMODE = 3;
    localparam int A_FMT    = 4;
    localparam int A_TXD    = 5;
    localparam int A_RXD    = 6;

    localparam logic [1:0] CSM_AUTO = 2'd0;
    localparam logic [1:0] CSM_HOLD = 2'd2;
    localparam logic [1:0] CSM_OFF  = 2'd3;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_ctrl_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 12,
    localparam int LEN_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div,
    input  logic               pol,
    input  logic               pha,
    input  logic               lsb_first,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic               tx_valid,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               rx_room,
    input  logic               miso,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_data,
    output logic               sck,
    output logic               mosi,
    output logic               busy
);

    eng_state_t         state_q, state_d;
    logic [DIV_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   bits_q, len_q, len_eff;
    logic               lsb_q;
    logic [FRAME_W-1:0] tsh_q, rsh_q;
    logic               half_done, start, lead_edge, trail_edge;
    logic               do_sample, do_shift;

    assign len_eff = (frame_len == '0 || frame_len > LEN_W'(FRAME_W))
                     ? LEN_W'(FRAME_W) : frame_len;
    assign half_done  = (cnt_q == div);
    assign start      = (state_q == ST_IDLE) && tx_valid && rx_room;
    assign lead_edge  = half_done && (state_q == ST_SETUP || state_q == ST_IDLEHALF);
    assign trail_edge = half_done && (state_q == ST_ACTIVE);
    assign do_sample  = pha ? trail_edge : lead_edge;
    assign do_shift   = pha ? (lead_edge && state_q == ST_IDLEHALF)
                            : (trail_edge && bits_q != LEN_W'(1));

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)     state_d = ST_SETUP;
            ST_SETUP:    if (half_done) state_d = ST_ACTIVE;
            ST_ACTIVE:   if (half_done) state_d = (bits_q == LEN_W'(1)) ? ST_HOLDOFF
                                                                         : ST_IDLEHALF;
            ST_IDLEHALF: if (half_done) state_d = ST_ACTIVE;
            ST_HOLDOFF:  if (half_done) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register and half-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE || state_d != state_q || half_done)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsh_q  <= '0;
            rsh_q  <= '0;
            bits_q <= '0;
            len_q  <= LEN_W'(FRAME_W);
            lsb_q  <= 1'b0;
        end else if (start) begin
            tsh_q  <= lsb_first ? tx_data : (tx_data << (FRAME_W - int'(len_eff)));
            rsh_q  <= '0;
            bits_q <= len_eff;
            len_q  <= len_eff;
            lsb_q  <= lsb_first;
        end else begin
            if (do_sample)
                rsh_q <= lsb_q ? {miso, rsh_q[FRAME_W-1:1]} : {rsh_q[FRAME_W-2:0], miso};
            if (do_shift)
                tsh_q <= lsb_q ? (tsh_q >> 1) : (tsh_q << 1);
            if (trail_edge)
                bits_q <= bits_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        sck     = pol ^ (state_q == ST_ACTIVE);
        mosi    = lsb_q ? tsh_q[0] : tsh_q[FRAME_W-1];
        busy    = (state_q != ST_IDLE);
        tx_pop  = start;
        rx_push = half_done && (state_q == ST_HOLDOFF);
        rx_data = lsb_q ? (rsh_q >> (FRAME_W - int'(len_q))) : rsh_q;
    end

endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
    import spi_ctrl_pkg::*;
#(
    parameter int FRAME_W    = 8,
    parameter int DIV_W      = 12,
    parameter int NCS        = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 3,
    localparam int LEN_W     = $clog2(FRAME_W + 1),
    localparam int CSSEL_W   = (NCS > 1) ? $clog2(NCS) : 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    output logic              sck,
    output logic              mosi,
    output logic [NCS-1:0]    cs_n,
    input  logic              miso
);

    logic [DIV_W-1:0]   div_q;
    logic               pol_q, pha_q, lsb_q, held_q;
    logic [CSSEL_W-1:0] cssel_q;
    logic [1:0]         csmode_q, proto_q;
    logic [LEN_W-1:0]   len_q;

    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic               rx_push, rx_pop, rx_full, rx_empty;
    logic [FRAME_W-1:0] tx_dout, rx_din, rx_dout;
    logic [CNT_W-1:0]   tx_cnt, rx_cnt;
    logic               eng_busy, cs_on;

    assign tx_push = reg_wr && (reg_addr == ADDR_W'(A_TXD));
    assign rx_pop  = reg_rd && (reg_addr == ADDR_W'(A_RXD));

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            pol_q    <= 1'b0;
            pha_q    <= 1'b0;
            cssel_q  <= '0;
            csmode_q <= CSM_AUTO;
            len_q    <= LEN_W'(FRAME_W);
            proto_q  <= '0;
            lsb_q    <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(A_DIV):    div_q    <= reg_wdata[DIV_W-1:0];
                ADDR_W'(A_MODE):   {pha_q, pol_q} <= reg_wdata[1:0];
                ADDR_W'(A_CSSEL):  cssel_q  <= reg_wdata[CSSEL_W-1:0];
                ADDR_W'(A_CSMODE): csmode_q <= reg_wdata[1:0];
                ADDR_W'(A_FMT): begin
                    len_q   <= reg_wdata[LEN_W-1:0];
                    proto_q <= reg_wdata[5:4];
                    lsb_q   <= reg_wdata[6];
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_DIV):    reg_rdata[DIV_W-1:0]   = div_q;
            ADDR_W'(A_MODE):   reg_rdata[1:0]         = {pha_q, pol_q};
            ADDR_W'(A_CSSEL):  reg_rdata[CSSEL_W-1:0] = cssel_q;
            ADDR_W'(A_CSMODE): reg_rdata[1:0]         = csmode_q;
            ADDR_W'(A_FMT): begin
                reg_rdata[LEN_W-1:0] = len_q;
                reg_rdata[5:4]       = proto_q;
                reg_rdata[6]         = lsb_q;
            end
            ADDR_W'(A_TXD):    reg_rdata[31] = tx_full;
            ADDR_W'(A_RXD): begin
                reg_rdata[31]          = rx_empty;
                reg_rdata[FRAME_W-1:0] = rx_dout;
            end
            default: ;
        endcase
    end

    spi_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[FRAME_W-1:0]),
        .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    spi_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    spi_shift_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .div(div_q), .pol(pol_q), .pha(pha_q),
        .lsb_first(lsb_q), .frame_len(len_q), .tx_valid(!tx_empty), .tx_data(tx_dout),
        .rx_room(!rx_full), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_din), .sck(sck), .mosi(mosi), .busy(eng_busy)
    );

    // chip-select hold tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (csmode_q != CSM_HOLD)
            held_q <= 1'b0;
        else if (tx_pop)
            held_q <= 1'b1;
    end

    assign cs_on = (csmode_q != CSM_OFF) &&
                   (eng_busy || (csmode_q == CSM_HOLD && held_q));

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(cs_on && cssel_q == CSSEL_W'(i));
    end

endmodule

// File: rtl/spi_master_ctrl_chk.sv
module spi_master_ctrl_chk #(
    parameter int NCS        = 4,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck,
    input logic [NCS-1:0]   cs_n,
    input logic             pol,
    input logic             busy,
    input logic [1:0]       csmode,
    input logic             tx_push,
    input logic             tx_full,
    input logic             tx_pop,
    input logic [CNT_W-1:0] tx_count,
    input logic             rx_full
);

    // R9
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R10
    cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csmode == 2'd3) |-> (&cs_n));

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == pol));

    // R6
    tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_pop) |=> (tx_count == $past(tx_count)));

    // R6
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CNT_W'(FIFO_DEPTH));

    // R8
    rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !rx_full);

endmodule

bind spi_master_ctrl spi_master_ctrl_chk #(.NCS(NCS), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .pol(pol_q), .busy(eng_busy),
    .csmode(csmode_q), .tx_push(tx_push), .tx_full(tx_full), .tx_pop(tx_pop),
    .tx_count(tx_cnt), .rx_full(rx_full)
);

// File: tb/spi_master_ctrl_tb_top.sv
module spi_master_ctrl_tb_top;

    localparam int NCS   = 4;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sck, mosi, miso = 1'b0;
    logic [NCS-1:0] cs_n;

    int n_checks = 0, n_fail = 0;

    spi_master_ctrl #(.NCS(NCS), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- peripheral model and scoreboard queues ----------------
    int   exp_rx[$], exp_mosi[$], slv_out[$];
    bit   s_en = 0, s_pol = 0, s_pha = 0, s_lsb = 0;
    int   s_len = 8, s_cnt = 0, s_sel = 0;
    logic [7:0] s_in = '0;
    time  t_lead = 0, hp_meas = 0;

    function automatic int bitpos(input int k);
        return s_lsb ? k : s_len - 1 - k;
    endfunction

    task automatic slave_present();
        if (slv_out.size() > 0) miso = slv_out[0][bitpos(s_cnt)];
        else                    miso = 1'b0;
    endtask

    task automatic slave_advance();
        s_cnt++;
        if (s_cnt == s_len) begin
            if (exp_mosi.size() > 0) begin
                int e = exp_mosi.pop_front();
                check(int'(s_in) == e, "R4 mosi frame", int'(s_in), e);
            end else
                check(0, "R6 unexpected frame on mosi", int'(s_in), 0);
            s_in = '0;
            if (slv_out.size() > 0) void'(slv_out.pop_front());
            s_cnt = 0;
        end
    endtask

    always @(sck) begin
        #1;
        if (s_en) begin
            if (sck != s_pol) begin
                t_lead = $time;
                if (!s_pha) s_in[bitpos(s_cnt)] = mosi;
                else        slave_present();
            end else begin
                hp_meas = $time - t_lead;
                if (s_pha) begin
                    s_in[bitpos(s_cnt)] = mosi;
                    slave_advance();
                end else begin
                    slave_advance();
                    slave_present();
                end
            end
        end
    end

    // chip-select monitor: counts releases of the selected line
    int  cs_rises = 0;
    logic cs_prev = 1'b1;
    always @(negedge clk) begin
        if (!cs_prev && cs_n[s_sel]) cs_rises++;
        cs_prev = cs_n[s_sel];
    end

    // ---------------- register driver ----------------
    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = 32'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a); reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic configure(input int dv, input int md, input int ln, input bit lsb,
                             input int csm, input int sel);
        s_en = 0;
        reg_write(0, dv);
        reg_write(1, md);
        reg_write(2, sel);
        reg_write(3, csm);
        reg_write(4, ln | (int'(lsb) << 6));
        s_pol = md[0]; s_pha = md[1]; s_lsb = lsb;
        s_len = (ln == 0 || ln > 8) ? 8 : ln;
        s_sel = sel; s_cnt = 0; s_in = '0;
        @(negedge clk);
        cs_prev = cs_n[s_sel];
        s_en = 1;
    endtask

    task automatic send_frame(input int tx, input int sw);
        int m = (1 << s_len) - 1;
        slv_out.push_back(sw);
        if (slv_out.size() == 1 && s_cnt == 0) slave_present();
        exp_mosi.push_back(tx & m);
        exp_rx.push_back(sw & m);
        reg_write(5, tx);
    endtask

    task automatic wait_frames(input int n, input int dv);
        repeat (n * ((2 * s_len + 2) * (dv + 1) + 6)) @(negedge clk);
    endtask

    // monitor side: pop received frames and compare against expectations
    task automatic drain(output int got);
        logic [31:0] d;
        got = 0;
        forever begin
            reg_read(6, d);
            if (d[31]) break;
            got++;
            if (exp_rx.size() > 0) begin
                int e = exp_rx.pop_front();
                check(d[30:0] == 31'(e), "R5/R7 rx frame", int'(d[30:0]), e);
            end else
                check(0, "R8 extra rx frame", int'(d[30:0]), 0);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cs_n == '1, "R1 cs_n idle", int'(cs_n), 15);
        check(sck == 1'b0, "R1 sck idle", int'(sck), 0);
        reg_read(5, d);
        check(d[31] == 1'b0, "R1 tx not full", int'(d[31]), 0);
        reg_read(6, d);
        check(d[31] == 1'b1, "R1 rx empty", int'(d[31]), 1);

        // R7 read when empty changes nothing
        reg_read(6, d);
        check(d[31] == 1'b1, "R7 empty read repeat", int'(d[31]), 1);

        // mode 0, MSB-first, 8 bits, AUTO on line 1
        configure(1, 0, 8, 0, 0, 1);
        cs_rises = 0;
        send_frame(8'hA5, 8'h3C);
        repeat (3) @(negedge clk);
        check(cs_n == 4'b1101, "R9/R11 selected line low", int'(cs_n), 13);
        send_frame(8'h5A, 8'hC3);
        send_frame(8'h01, 8'h80);
        wait_frames(3, 1);
        check(cs_n == '1, "R9 released after frames", int'(cs_n), 15);
        check(cs_rises == 3, "R9 released per frame", cs_rises, 3);
        drain(got);
        check(got == 3, "R8 one rx per tx", got, 3);

        // mode 3, LSB-first, 5 bits, slower clock
        configure(3, 3, 5, 1, 0, 0);
        check(sck == 1'b1, "R3 idle high", int'(sck), 1);
        send_frame(8'h13, 8'h0B);
        send_frame(8'h0E, 8'h15);
        wait_frames(2, 3);
        check(hp_meas == 32, "R2 half period", int'(hp_meas), 32);
        drain(got);
        check(got == 2, "R5 short frames", got, 2);

        // mode 1, zero length means 8, MSB-first, fastest clock
        configure(0, 2, 0, 0, 0, 3);
        check(sck == 1'b0, "R3 idle low", int'(sck), 0);
        send_frame(8'hF0, 8'h69);
        wait_frames(1, 0);
        check(hp_meas == 8, "R2 div zero", int'(hp_meas), 8);
        drain(got);
        check(got == 1, "R5 zero length", got, 1);

        // HOLD on line 2
        configure(1, 1, 8, 0, 2, 2);
        cs_rises = 0;
        send_frame(8'h11, 8'h22);
        send_frame(8'h33, 8'h44);
        wait_frames(2, 1);
        check(cs_rises == 0, "R10 hold between frames", cs_rises, 0);
        check(cs_n == 4'b1011, "R10 hold after frames", int'(cs_n), 11);
        drain(got);

        // OFF: all lines high during a frame
        configure(1, 0, 8, 0, 3, 2);
        check(cs_n == '1, "R10 off releases", int'(cs_n), 15);
        send_frame(8'h77, 8'h66);
        repeat (6) @(negedge clk);
        check(cs_n == '1, "R10 off during frame", int'(cs_n), 15);
        wait_frames(1, 1);
        drain(got);
        check(got == 1, "R10 off frame data", got, 1);

        // FIFO limits: transmit full/drop, receive full stall
        configure(20, 0, 8, 0, 0, 0);
        send_frame(8'hC1, 8'h1C);
        send_frame(8'hC2, 8'h2C);
        send_frame(8'hC3, 8'h3C);
        send_frame(8'hC4, 8'h4C);
        send_frame(8'hC5, 8'h5C);
        reg_write(5, 8'hEE);             // dropped: FIFO full
        reg_read(5, d);
        check(d[31] == 1'b1, "R6 full flag", int'(d[31]), 1);
        wait_frames(5, 20);
        check(cs_n == '1, "R8 stalled while rx full", int'(cs_n), 15);
        reg_read(5, d);
        check(d[31] == 1'b0, "R6 full cleared", int'(d[31]), 0);
        drain(got);
        wait_frames(1, 20);
        begin
            int got2;
            drain(got2);
            check(got + got2 == 5, "R6/R8 dropped write not sent", got + got2, 5);
        end
        check(exp_mosi.size() == 0, "R6 all frames seen", exp_mosi.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule